// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects 32 level-sensitive interrupt sources and presents them to a processor on two outputs. One is a fast interrupt, `fiq_o`, and the other is a normal interrupt, `irq_o`. A request on any source can come from its hardware line or from a software-set bit held in the block. A per-source select register steers each request to one of the two outputs. The normal path is also gated by an enable mask.

Sixteen vector slots are ranked by slot index, with slot 0 the most urgent. Each slot names one source and holds a handler address. The block keeps a current priority level from 0 to 17, where 17 means no handler is running. It also keeps a history entry for every level. When a handler reads the vector register, the level rises to that of the most urgent pending request, and the handler's address is returned. Writing the vector register when the handler finishes brings back the level that was active before. While a handler runs, `irq_o` is raised only by sources in slots more urgent than the running one, so nested pre-emption works without software masking.

Software reaches the block over a simple word-addressed register bus. Read data is registered and stays valid until the next read strobe.

Top module: `vnic_top`

## Requirements
- R1: The raw request of each source is its `req_in` bit OR its software request bit. Raw status reads at offset 0x08.
- R2: Offset 0x00 reads raw AND enable AND NOT select. Writes to 0x00 are ignored.
- R3: Offset 0x04 reads raw AND select, regardless of the enable mask. `fiq_o` is high one cycle after that value becomes nonzero. The select mask is read/write at 0x0C.
- R4: Writing ones to 0x10 sets enable bits and writing ones to 0x14 clears them. Zero bits leave the mask unchanged. Offset 0x10 reads the mask.
- R5: Writing ones to 0x18 sets software request bits and writing ones to 0x1C clears them. Offset 0x18 reads the mask.
- R6: Slot k has its address word at 0x100+4k and its control byte at 0x200+4k. Both read back as written, with the control byte stored in bits 7:0. In the control byte, bit 5 enables the slot and bits 4:0 select the source.
- R7: For a level p from 0 to 16, the level mask holds the sources of enabled slots with index below p. Level 17 has an all-ones mask. `irq_o` is high one cycle after (0x00 status AND mask of the current level) becomes nonzero.
- R8: A read of 0x30 finds the least i below the current level for which raw AND mask(i+1) is nonzero. If such an i exists, the current level is saved as history(i) and the level becomes i. The read returns the slot address of the resulting level. At level 16 or 17 it returns the default vector at 0x34.
- R9: A write to 0x30 ignores its data and sets the level to history(current level). When the level is 17, the write has no effect.
- R10: Reset clears all masks, slot words, control bytes, the default vector, the outputs and the read data. The level and all history entries are set to 17.
- R11: Offset 0x20 keeps only bit 0. Offsets 0xFE0 to 0xFFC return the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word. Every other offset, and any unaligned address, reads 0.
- R12: `bus_rdata` updates on the clock edge that samples `bus_rd`, and holds its value while `bus_rd` is low. Each cycle with `bus_rd` high is one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| req_in | input | 32 | Hardware request lines, level sensitive |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The nesting logic is driven with three kinds of pending set:
- A single vectored source reached from idle checks the upward search and the masking that follows.
- A more urgent source added while a handler runs checks pre-emption.
- A less urgent source added at the same point checks that it stays blocked.

A source enabled but in no slot separates level 16 from the idle level and checks the default vector. An empty pending set separates the no-change read from a real acknowledge. Vector writes at each nesting depth, including idle, show that history unwinds in the right order. Plain register patterns set bits and clear bits in separate steps, so that set-only and clear-only behaviour can be told apart from a plain overwrite.

// File: rtl/vnic_pkg.sv
`timescale 1ns/1ps
package vnic_pkg;

    localparam int DEF_NSRC  = 32;
    localparam int DEF_NSLOT = 16;
    localparam int DEF_DW    = 32;
    localparam int DEF_AW    = 12;

    // word indices inside the low register page
    localparam int W_IRQSTAT = 0;
    localparam int W_FIQSTAT = 1;
    localparam int W_RAW     = 2;
    localparam int W_FSEL    = 3;
    localparam int W_ENSET   = 4;
    localparam int W_ENCLR   = 5;
    localparam int W_SWSET   = 6;
    localparam int W_SWCLR   = 7;
    localparam int W_PROT    = 8;
    localparam int W_VEC     = 12;
    localparam int W_DEFVEC  = 13;

    // slot control byte: bit 5 enable, bits 4:0 source
    typedef struct packed {
        logic [1:0] spare;
        logic       en;
        logic [4:0] src;
    } slot_ctrl_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h90;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/vnic_level_masks.sv
`timescale 1ns/1ps
module vnic_level_masks
    import vnic_pkg::*;
#(
    parameter int NSRC  = DEF_NSRC,
    parameter int NSLOT = DEF_NSLOT
) (
    input  slot_ctrl_t       ctrl     [NSLOT],
    output logic [NSRC-1:0]  lvl_mask [NSLOT+2]
);

    assign lvl_mask[0] = '0;

    // each level inherits the sources of every more urgent enabled slot
    for (genvar p = 1; p <= NSLOT; p++) begin : g_lvl
        logic [NSRC-1:0] pick;
        assign pick        = ctrl[p-1].en ? (NSRC'(1) << ctrl[p-1].src) : '0;
        assign lvl_mask[p] = lvl_mask[p-1] | pick;
    end

    assign lvl_mask[NSLOT+1] = '1;

endmodule

// File: rtl/vnic_nest_ctrl.sv
`timescale 1ns/1ps
module vnic_nest_ctrl
    import vnic_pkg::*;
#(
    parameter int NSRC  = DEF_NSRC,
    parameter int NSLOT = DEF_NSLOT,
    parameter int LVL_W = $clog2(DEF_NSLOT + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  raw,
    input  logic [NSRC-1:0]  lvl_mask [NSLOT+2],
    input  logic             vec_rd,
    input  logic             vec_wr,
    output logic [LVL_W-1:0] cur_lvl,
    output logic [LVL_W-1:0] ack_lvl
);

    localparam logic [LVL_W-1:0] IDLE = LVL_W'(NSLOT + 1);

    logic [LVL_W-1:0] hist [NSLOT+1];
    logic             hit;

    // first level below the current one with a raw request in its next mask
    always_comb begin
        ack_lvl = cur_lvl;
        hit     = 1'b0;
        for (int i = 0; i <= NSLOT; i++) begin
            if (!hit && (LVL_W'(i) < cur_lvl) && (|(raw & lvl_mask[i+1]))) begin
                ack_lvl = LVL_W'(i);
                hit     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lvl <= IDLE;
            for (int i = 0; i <= NSLOT; i++) hist[i] <= IDLE;
        end else if (vec_wr) begin
            if (cur_lvl < IDLE) cur_lvl <= hist[cur_lvl];
        end else if (vec_rd && hit) begin
            hist[ack_lvl] <= cur_lvl;
            cur_lvl       <= ack_lvl;
        end
    end

    // R8
    lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
        cur_lvl <= IDLE);

    // R8
    ack_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && !vec_wr) |=> cur_lvl <= $past(cur_lvl));

    // R9
    idle_end_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_wr && cur_lvl == IDLE) |=> cur_lvl == IDLE);

    // R10
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cur_lvl == IDLE);

endmodule

// File: rtl/vnic_top.sv
`timescale 1ns/1ps
module vnic_top
    import vnic_pkg::*;
#(
    parameter int NSRC  = DEF_NSRC,
    parameter int NSLOT = DEF_NSLOT,
    parameter int DW    = DEF_DW,
    parameter int AW    = DEF_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic [NSRC-1:0] req_in,
    output logic          irq_o,
    output logic          fiq_o
);

    localparam int LVL_W  = $clog2(NSLOT + 2);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int PAGE_W = AW - SLOT_W - 2;
    localparam logic [PAGE_W-1:0] PG_VADDR = PAGE_W'(12'h100 >> (SLOT_W + 2));
    localparam logic [PAGE_W-1:0] PG_VCTRL = PAGE_W'(12'h200 >> (SLOT_W + 2));
    localparam logic [AW-6:0]     PG_ID    = '1;

    logic [NSRC-1:0] sw_q, en_q, fsel_q;
    logic            prot_q;
    logic [DW-1:0]   vaddr_q [NSLOT+1];
    slot_ctrl_t      ctrl_q  [NSLOT];
    logic [DW-1:0]   rdata_q;
    logic            irq_q, fiq_q;

    logic [NSRC-1:0] raw, irq_stat, fiq_stat;
    logic [NSRC-1:0] lvl_mask [NSLOT+2];
    logic [LVL_W-1:0] cur_lvl, ack_lvl;
    logic [DW-1:0]   vec_val, rd_val;

    logic              aligned;
    logic [AW-3:0]     word;
    logic [SLOT_W-1:0] slot;
    logic              in_vaddr, in_vctrl, in_id;
    logic              vec_rd, vec_wr;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word     = bus_addr[AW-1:2];
    assign slot     = bus_addr[SLOT_W+1:2];
    assign in_vaddr = aligned && (bus_addr[AW-1:SLOT_W+2] == PG_VADDR);
    assign in_vctrl = aligned && (bus_addr[AW-1:SLOT_W+2] == PG_VCTRL);
    assign in_id    = aligned && (bus_addr[AW-1:5] == PG_ID);
    assign vec_rd   = bus_rd && aligned && (word == (AW-2)'(W_VEC));
    assign vec_wr   = bus_we && aligned && (word == (AW-2)'(W_VEC));

    assign raw      = req_in | sw_q;
    assign irq_stat = raw & en_q & ~fsel_q;
    assign fiq_stat = raw & fsel_q;

    vnic_level_masks #(.NSRC(NSRC), .NSLOT(NSLOT)) u_masks (
        .ctrl     (ctrl_q),
        .lvl_mask (lvl_mask)
    );

    vnic_nest_ctrl #(.NSRC(NSRC), .NSLOT(NSLOT), .LVL_W(LVL_W)) u_nest (
        .clk      (clk),
        .rst      (rst),
        .raw      (raw),
        .lvl_mask (lvl_mask),
        .vec_rd   (vec_rd),
        .vec_wr   (vec_wr),
        .cur_lvl  (cur_lvl),
        .ack_lvl  (ack_lvl)
    );

    assign vec_val = (ack_lvl >= LVL_W'(NSLOT)) ? vaddr_q[NSLOT]
                                                 : vaddr_q[ack_lvl[SLOT_W-1:0]];

    always_comb begin
        rd_val = '0;
        if (in_vaddr) begin
            rd_val = vaddr_q[slot];
        end else if (in_vctrl) begin
            rd_val = DW'(ctrl_q[slot]);
        end else if (in_id) begin
            rd_val = DW'(id_byte(bus_addr[4:2]));
        end else if (aligned) begin
            case (int'(word))
                W_IRQSTAT: rd_val = DW'(irq_stat);
                W_FIQSTAT: rd_val = DW'(fiq_stat);
                W_RAW:     rd_val = DW'(raw);
                W_FSEL:    rd_val = DW'(fsel_q);
                W_ENSET:   rd_val = DW'(en_q);
                W_SWSET:   rd_val = DW'(sw_q);
                W_PROT:    rd_val = DW'(prot_q);
                W_VEC:     rd_val = vec_val;
                W_DEFVEC:  rd_val = vaddr_q[NSLOT];
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q    <= '0;
            en_q    <= '0;
            fsel_q  <= '0;
            prot_q  <= 1'b0;
            rdata_q <= '0;
            for (int k = 0; k <= NSLOT; k++) vaddr_q[k] <= '0;
            for (int k = 0; k < NSLOT; k++)  ctrl_q[k]  <= '0;
        end else begin
            if (bus_rd) rdata_q <= rd_val;
            if (bus_we) begin
                if (in_vaddr) begin
                    vaddr_q[slot] <= bus_wdata;
                end else if (in_vctrl) begin
                    ctrl_q[slot] <= slot_ctrl_t'(bus_wdata[7:0]);
                end else if (aligned) begin
                    case (int'(word))
                        W_FSEL:   fsel_q <= bus_wdata[NSRC-1:0];
                        W_ENSET:  en_q   <= en_q | bus_wdata[NSRC-1:0];
                        W_ENCLR:  en_q   <= en_q & ~bus_wdata[NSRC-1:0];
                        W_SWSET:  sw_q   <= sw_q | bus_wdata[NSRC-1:0];
                        W_SWCLR:  sw_q   <= sw_q & ~bus_wdata[NSRC-1:0];
                        W_PROT:   prot_q <= bus_wdata[0];
                        W_DEFVEC: vaddr_q[NSLOT] <= bus_wdata;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |(irq_stat & lvl_mask[cur_lvl]);
            fiq_q <= |fiq_stat;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_o     = irq_q;
    assign fiq_o     = fiq_q;

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|irq_stat));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && aligned && word == (AW-2)'(W_ENSET))
        |=> (en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]));

    // R5
    sw_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && aligned && word == (AW-2)'(W_SWCLR))
        |=> (sw_q & $past(bus_wdata[NSRC-1:0])) == '0);

endmodule

// File: tb/vnic_top_tb.sv
`timescale 1ns/1ps
module vnic_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] req_in = '0;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vnic_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .req_in    (req_in),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    // {op(1=read check, 0=write), req, addr, wdata, expected}
    localparam int NV = 36;
    localparam logic [81:0] VEC [NV] = '{
        {2'd1, 4'd10, 12'h008, 32'h0,        32'h0},      // R10 raw after reset
        {2'd0, 4'd5,  12'h018, 32'h000000F0, 32'h0},      // R5 set soft
        {2'd1, 4'd1,  12'h008, 32'h0,        32'h000000F0}, // R1 raw from soft
        {2'd1, 4'd5,  12'h018, 32'h0,        32'h000000F0}, // R5
        {2'd0, 4'd5,  12'h01C, 32'h00000030, 32'h0},      // R5 clear
        {2'd1, 4'd5,  12'h018, 32'h0,        32'h000000C0},
        {2'd0, 4'd4,  12'h010, 32'h000000A0, 32'h0},      // R4 set
        {2'd0, 4'd4,  12'h010, 32'h00000001, 32'h0},
        {2'd1, 4'd4,  12'h010, 32'h0,        32'h000000A1},
        {2'd0, 4'd4,  12'h014, 32'h00000080, 32'h0},      // R4 clear
        {2'd1, 4'd4,  12'h010, 32'h0,        32'h00000021},
        {2'd0, 4'd3,  12'h00C, 32'h00000040, 32'h0},      // R3 select
        {2'd1, 4'd3,  12'h00C, 32'h0,        32'h00000040},
        {2'd1, 4'd3,  12'h004, 32'h0,        32'h00000040}, // R3 not gated by enable
        {2'd1, 4'd2,  12'h000, 32'h0,        32'h0},      // R2
        {2'd0, 4'd2,  12'h010, 32'h00000080, 32'h0},
        {2'd1, 4'd2,  12'h000, 32'h0,        32'h00000080},
        {2'd0, 4'd2,  12'h000, 32'hFFFFFFFF, 32'h0},      // R2 write ignored
        {2'd1, 4'd2,  12'h000, 32'h0,        32'h00000080},
        {2'd0, 4'd11, 12'h020, 32'h0000FFFF, 32'h0},      // R11 protection
        {2'd1, 4'd11, 12'h020, 32'h0,        32'h00000001},
        {2'd1, 4'd11, 12'hFE0, 32'h0,        32'h00000090}, // R11 id
        {2'd1, 4'd11, 12'hFE4, 32'h0,        32'h00000011},
        {2'd1, 4'd11, 12'hFF4, 32'h0,        32'h000000F0},
        {2'd1, 4'd11, 12'hFFC, 32'h0,        32'h000000B1},
        {2'd1, 4'd11, 12'h040, 32'h0,        32'h0},      // R11 unmapped
        {2'd1, 4'd10, 12'h034, 32'h0,        32'h0},      // R10 default vector
        {2'd0, 4'd6,  12'h104, 32'h00001234, 32'h0},      // R6 slot address
        {2'd1, 4'd6,  12'h104, 32'h0,        32'h00001234},
        {2'd0, 4'd6,  12'h23C, 32'h000001FF, 32'h0},      // R6 control byte
        {2'd1, 4'd6,  12'h23C, 32'h0,        32'h000000FF},
        {2'd0, 4'd6,  12'h23C, 32'h0,        32'h0},
        {2'd0, 4'd5,  12'h01C, 32'hFFFFFFFF, 32'h0},
        {2'd0, 4'd4,  12'h014, 32'hFFFFFFFF, 32'h0},
        {2'd0, 4'd3,  12'h00C, 32'h0,        32'h0},
        {2'd1, 4'd1,  12'h008, 32'h0,        32'h0}       // R1 all clear
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp,
                          input int req, input string what);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        check(req, what, bus_rdata, exp);
    endtask

    task automatic irq_chk(input logic e, input int req);
        @(negedge clk);
        check(req, "irq_o", {31'b0, irq_o}, {31'b0, e});
    endtask

    task automatic fiq_chk(input logic e, input int req);
        @(negedge clk);
        check(req, "fiq_o", {31'b0, fiq_o}, {31'b0, e});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state at the ports
        check(10, "irq after reset", {31'b0, irq_o}, 32'h0);
        check(10, "fiq after reset", {31'b0, fiq_o}, 32'h0);
        check(10, "rdata after reset", bus_rdata, 32'h0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][81:80] == 2'd0)
                wr(VEC[k][75:64], VEC[k][63:32]);
            else
                rd_chk(VEC[k][75:64], VEC[k][31:0], int'(VEC[k][79:76]), "table");
        end

        // slots: 0 -> src5, 1 -> src9, 2 -> src3; src20 enabled but unslotted
        wr(12'h100, 32'h0000A000);
        wr(12'h104, 32'h0000A100);
        wr(12'h108, 32'h0000A200);
        wr(12'h034, 32'h0000DEF0);
        wr(12'h200, 32'h25);
        wr(12'h204, 32'h29);
        wr(12'h208, 32'h23);
        wr(12'h010, 32'h00100228);
        irq_chk(1'b0, 7);

        req_in = 32'h1 << 9;
        irq_chk(1'b1, 7);                       // R7 idle passes any status
        rd_chk(12'h030, 32'h0000A100, 8, "ack src9");  // R8
        irq_chk(1'b0, 7);                       // R7 level 1 masks src9

        req_in = req_in | (32'h1 << 5);
        irq_chk(1'b1, 7);                       // R7 pre-emption by slot 0
        rd_chk(12'h030, 32'h0000A000, 8, "ack src5 nested");
        irq_chk(1'b0, 7);

        req_in = req_in | (32'h1 << 3);
        irq_chk(1'b0, 7);                       // R7 less urgent blocked
        rd_chk(12'h030, 32'h0000A000, 8, "read at level 0 no change");

        wr(12'h030, 32'hFFFFFFFF);              // R9 back to level 1
        irq_chk(1'b1, 9);
        req_in = req_in & ~(32'h1 << 5);
        irq_chk(1'b0, 9);
        wr(12'h030, 32'h0);                     // R9 back to idle
        irq_chk(1'b1, 9);
        rd_chk(12'h030, 32'h0000A100, 8, "re-ack src9");
        wr(12'h030, 32'h0);

        req_in = 32'h1 << 20;
        irq_chk(1'b1, 7);
        rd_chk(12'h030, 32'h0000DEF0, 8, "unslotted -> default");  // R8 level 16
        irq_chk(1'b0, 7);
        wr(12'h030, 32'h0);
        irq_chk(1'b1, 9);

        req_in = 32'h0;
        irq_chk(1'b0, 7);
        rd_chk(12'h030, 32'h0000DEF0, 8, "nothing pending");
        wr(12'h030, 32'h0);                     // R9 at idle: no effect
        req_in = 32'h1 << 9;
        irq_chk(1'b1, 9);
        rd_chk(12'h030, 32'h0000A100, 9, "still idle before ack");
        repeat (3) @(negedge clk);
        check(12, "rdata held", bus_rdata, 32'h0000A100);  // R12
        wr(12'h030, 32'h0);

        // R3 fast path ignores enable
        req_in = 32'h0;
        wr(12'h014, 32'h8);
        wr(12'h00C, 32'h8);
        req_in = 32'h1 << 3;
        fiq_chk(1'b1, 3);
        irq_chk(1'b0, 3);
        rd_chk(12'h004, 32'h8, 3, "fiq status");

        // R10 reset in the middle of activity
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        fiq_chk(1'b0, 10);
        rd_chk(12'h00C, 32'h0, 10, "select cleared");
        rd_chk(12'h100, 32'h0, 10, "slot address cleared");
        rd_chk(12'h030, 32'h0, 10, "default vector cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule